// File: doc/BRIEF.md
# Switchable Aging / Fixed-Priority Transaction Scheduler

This block sits between a set of processor cores and one memory port. Read requests come in over a small number of input links, and each link is shared by a pair of cores. The target address of a request decides which core, and so which per-core queue, it belongs to. Every core has its own FIFO. On each cycle in which the output register is free or is being emptied, the scheduler picks one queue head and moves it into a registered output that follows valid/ready handshaking.

Two arbitration policies are available, and a configuration write port selects between them at run time. The aging policy counts how long each waiting head has been passed over and serves the one that has waited longest. The fixed-priority policy serves the non-empty queue that has the highest programmed priority. A single policy always applies to all cores. A newly written policy takes effect only at a cycle where the output is not holding a stalled transaction.

Top module: `txsched_top`

## Requirements
- R1: Requests of one core leave in the order they arrived. A request pushed into an empty scheduler with an empty output appears on `m_valid`/`m_addr` one cycle later. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr` and `m_core` hold steady.
- R2: In aging mode (policy code 0), each queue has a counter for its head. The counter rises by one on every cycle in which the head is present and not granted. The grant goes to the head with the largest count.
- R3: A head's counter returns to zero when that head is granted or when its queue is empty. The next head of a queue therefore starts with a count of zero.
- R4: When counts are equal in aging mode, the lowest core index wins.
- R5: Counters stop at their all-ones value and do not wrap.
- R6: In fixed mode (policy code 1), the non-empty queue with the largest priority value wins. The priority of core k is written at configuration address 1+k, in the low PRIO_W data bits. After reset, core k has priority k.
- R7: The policy register is at configuration address 0 and uses data bits [1:0]. Only codes 0 and 1 are accepted. Any other code is ignored and the current policy stays in force. The policy after reset is aging.
- R8: A written policy becomes active at the first clock edge at which the output is empty or being accepted. The grant made at that same edge still uses the previous policy.
- R9: Link l feeds cores 2l and 2l+1. A request goes to core c when (addr & mask_c) == base_c. The lower core of the pair is checked first. base_c is written at configuration address 8+2c and mask_c at 9+2c. After reset, mask_c covers the top log2(cores) address bits and base_c holds c in those bits.
- R10: A request that matches neither core of its link is accepted and discarded, and it produces no output.
- R11: `in_ready` of a link is low exactly when the request's target queue is full. Other links and the other core of the same link are not affected.
- R12: After reset, `m_valid` is low and every `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NUM_LINKS | Request valid, one bit per link |
| in_addr | input | NUM_LINKS*ADDR_W | Request address, link l in slice l |
| in_ready | output | NUM_LINKS | Link can accept its current request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register address |
| cfg_wdata | input | ADDR_W | Configuration write data |
| m_valid | output | 1 | Memory-side request valid |
| m_ready | input | 1 | Memory side accepts request |
| m_addr | output | ADDR_W | Forwarded request address |
| m_core | output | log2(2*NUM_LINKS) | Core that owns the forwarded request |

## Verification
The bench uses the default build: two links, four cores, four-entry queues, 4-bit age counters and 2-bit priorities. With counters that saturate at 15, the bench can stall the output for about thirty cycles and drive every waiting head to its ceiling, which exposes both saturation and the lowest-index tie rule. Four-entry queues fill with five back-to-back pushes, so back-pressure is reached quickly. With four cores, all orderings under both policies, and a policy switch during a stall, can be checked against expected sequences worked out by hand.

// File: rtl/txsched_pkg.sv
// Shared constants and types for the transaction scheduler.
package txsched_pkg;
    typedef enum logic [1:0] {
        POL_AGING = 2'd0,
        POL_FIXED = 2'd1
    } policy_e;

    localparam int CFG_POLICY_ADDR = 0;  // policy select register
    localparam int CFG_PRIO_ADDR0  = 1;  // priority of core k at 1+k
    localparam int CFG_ROUTE_ADDR0 = 8;  // base of core k at 8+2k, mask at 9+2k
endpackage

// File: rtl/txsched_fifo.sv
// Per-core request queue: a plain synchronous FIFO.
// Assumes the caller never pushes when full and never pops when empty.
module txsched_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push && !full)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop && !empty)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push && !full, pop && !empty})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/txsched_link.sv
// Input link demultiplexer: sends a request to one of two cores by base/mask match.
// The lower core wins when both match. A request that matches neither core is
// accepted and dropped. Purely combinational.
module txsched_link #(
    parameter int ADDR_W = 32
) (
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [ADDR_W-1:0] base_lo,
    input  logic [ADDR_W-1:0] mask_lo,
    input  logic [ADDR_W-1:0] base_hi,
    input  logic [ADDR_W-1:0] mask_hi,
    input  logic              full_lo,
    input  logic              full_hi,
    output logic              in_ready,
    output logic              push_lo,
    output logic              push_hi
);
    logic hit_lo, hit_hi;

    // Region decode with lower-core precedence.
    always_comb begin
        hit_lo   = ((in_addr & mask_lo) == base_lo);
        hit_hi   = !hit_lo && ((in_addr & mask_hi) == base_hi);
        in_ready = hit_lo ? !full_lo : (hit_hi ? !full_hi : 1'b1);
        push_lo  = in_valid && hit_lo && !full_lo;
        push_hi  = in_valid && hit_hi && !full_hi;
    end
endmodule

// File: rtl/txsched_arbiter.sv
// Queue-head arbiter with per-queue saturating age counters.
// Aging mode grants the largest age; fixed mode grants the largest priority.
// Equal values go to the lowest index. A grant is issued only while enable is high.
module txsched_arbiter #(
    parameter int NQ     = 4,
    parameter int AGE_W  = 4,
    parameter int PRIO_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NQ-1:0]        head_valid,
    input  logic [NQ*PRIO_W-1:0] prio_flat,
    input  logic                 fixed_mode,
    input  logic                 enable,
    output logic [NQ-1:0]        grant
);
    localparam int IDX_W = (NQ > 1) ? $clog2(NQ) : 1;
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [AGE_W-1:0]  age_q [NQ];
    logic              found;
    logic [IDX_W-1:0]  best_idx;
    logic [AGE_W-1:0]  best_age;
    logic [PRIO_W-1:0] best_prio;

    // Winner search: strict compare keeps the lowest index on ties.
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_age  = '0;
        best_prio = '0;
        for (int i = 0; i < NQ; i++) begin
            if (head_valid[i]) begin
                if (!found ||
                    (fixed_mode  && (prio_flat[i*PRIO_W +: PRIO_W] > best_prio)) ||
                    (!fixed_mode && (age_q[i] > best_age))) begin
                    found     = 1'b1;
                    best_idx  = IDX_W'(i);
                    best_age  = age_q[i];
                    best_prio = prio_flat[i*PRIO_W +: PRIO_W];
                end
            end
        end
        grant = (enable && found) ? (NQ'(1) << best_idx) : '0;
    end

    // Age counting: clear on grant or empty queue, otherwise saturating increment.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NQ; i++) begin
            if (!rst_n || !head_valid[i] || grant[i])
                age_q[i] <= '0;
            else if (age_q[i] != AGE_MAX)
                age_q[i] <= age_q[i] + 1'b1;
        end
    end

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_needs_head_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((grant & head_valid) == grant) && enable);

    for (genvar g = 0; g < NQ; g++) begin : g_age_chk
        p_age_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (head_valid[g] && !grant[g] && age_q[g] == AGE_MAX) |=> age_q[g] == AGE_MAX);
        p_age_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] |=> age_q[g] == '0);
    end
endmodule

// File: rtl/txsched_top.sv
// Transaction scheduler top: configuration registers, link demultiplexers,
// per-core FIFOs, arbiter and a registered valid/ready output stage.
// Assumes programmed priorities are unique; ties fall to the lowest core index.
module txsched_top #(
    parameter int NUM_LINKS  = 2,
    parameter int ADDR_W     = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int AGE_W      = 4,
    parameter int PRIO_W     = 2,
    parameter int CFG_AW     = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINKS-1:0]          in_valid,
    input  logic [NUM_LINKS*ADDR_W-1:0]   in_addr,
    output logic [NUM_LINKS-1:0]          in_ready,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    output logic                          m_valid,
    input  logic                          m_ready,
    output logic [ADDR_W-1:0]             m_addr,
    output logic [$clog2(2*NUM_LINKS)-1:0] m_core
);
    import txsched_pkg::*;

    localparam int NCORE  = 2 * NUM_LINKS;
    localparam int CORE_W = $clog2(NCORE);
    localparam logic [ADDR_W-1:0] RESET_MASK = {{CORE_W{1'b1}}, {(ADDR_W-CORE_W){1'b0}}};

    policy_e                   pend_pol, act_pol;
    logic [NCORE*PRIO_W-1:0]   prio_q;
    logic [ADDR_W-1:0]         base_q [NCORE];
    logic [ADDR_W-1:0]         mask_q [NCORE];
    logic [NCORE-1:0]          push, full, empty, grant;
    logic [ADDR_W-1:0]         head_addr [NCORE];
    logic                      load_en;
    logic                      out_valid;
    logic [ADDR_W-1:0]         out_addr;
    logic [CORE_W-1:0]         out_core, grant_idx;
    logic [ADDR_W-1:0]         grant_addr;

    // Configuration register writes; unknown policy codes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pol <= POL_AGING;
            for (int k = 0; k < NCORE; k++) begin
                prio_q[k*PRIO_W +: PRIO_W] <= PRIO_W'(k);
                base_q[k] <= ADDR_W'(k) << (ADDR_W - CORE_W);
                mask_q[k] <= RESET_MASK;
            end
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(CFG_POLICY_ADDR) &&
                (cfg_wdata[1:0] == POL_AGING || cfg_wdata[1:0] == POL_FIXED))
                pend_pol <= policy_e'(cfg_wdata[1:0]);
            for (int k = 0; k < NCORE; k++) begin
                if (cfg_addr == CFG_AW'(CFG_PRIO_ADDR0 + k))
                    prio_q[k*PRIO_W +: PRIO_W] <= cfg_wdata[PRIO_W-1:0];
                if (cfg_addr == CFG_AW'(CFG_ROUTE_ADDR0 + 2*k))
                    base_q[k] <= cfg_wdata;
                if (cfg_addr == CFG_AW'(CFG_ROUTE_ADDR0 + 2*k + 1))
                    mask_q[k] <= cfg_wdata;
            end
        end
    end

    assign load_en = !out_valid || m_ready;

    // Policy hand-over only while no transaction is held in the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n)       act_pol <= POL_AGING;
        else if (load_en) act_pol <= pend_pol;
    end

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
        txsched_link #(.ADDR_W(ADDR_W)) u_link (
            .in_valid (in_valid[l]),
            .in_addr  (in_addr[l*ADDR_W +: ADDR_W]),
            .base_lo  (base_q[2*l]),
            .mask_lo  (mask_q[2*l]),
            .base_hi  (base_q[2*l+1]),
            .mask_hi  (mask_q[2*l+1]),
            .full_lo  (full[2*l]),
            .full_hi  (full[2*l+1]),
            .in_ready (in_ready[l]),
            .push_lo  (push[2*l]),
            .push_hi  (push[2*l+1])
        );
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_queue
        txsched_fifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[c]),
            .din   (in_addr[(c/2)*ADDR_W +: ADDR_W]),
            .pop   (grant[c]),
            .dout  (head_addr[c]),
            .empty (empty[c]),
            .full  (full[c])
        );
    end

    txsched_arbiter #(.NQ(NCORE), .AGE_W(AGE_W), .PRIO_W(PRIO_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (~empty),
        .prio_flat  (prio_q),
        .fixed_mode (act_pol == POL_FIXED),
        .enable     (load_en),
        .grant      (grant)
    );

    // One-hot grant to index and selected head.
    always_comb begin
        grant_idx  = '0;
        grant_addr = '0;
        for (int k = 0; k < NCORE; k++) begin
            if (grant[k]) begin
                grant_idx  = CORE_W'(k);
                grant_addr = head_addr[k];
            end
        end
    end

    // Registered output stage with valid/ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_core  <= '0;
        end else if (load_en) begin
            out_valid <= (grant != '0);
            if (grant != '0) begin
                out_addr <= grant_addr;
                out_core <= grant_idx;
            end
        end
    end

    assign m_valid = out_valid;
    assign m_addr  = out_addr;
    assign m_core  = out_core;

    p_hold_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_core)));
    p_policy_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> $stable(act_pol));
    p_policy_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_pol == POL_AGING) || (pend_pol == POL_FIXED));
endmodule

// File: tb/txsched_top_test.sv
module txsched_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_valid = '0;
    logic [63:0] in_addr = '0;
    logic [1:0]  in_ready;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [31:0] m_addr;
    logic [1:0]  m_core;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    txsched_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_ready(in_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .m_valid(m_valid), .m_ready(m_ready),
        .m_addr(m_addr), .m_core(m_core)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input int l, input logic [31:0] a);
        in_valid[l] = 1'b1;
        in_addr[l*32 +: 32] = a;
        @(negedge clk);
        in_valid[l] = 1'b0;
    endtask

    task automatic cfg_write(input int a, input logic [31:0] d);
        cfg_we = 1'b1;
        cfg_addr = 6'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expects next output with m_ready held high; returns at the following negedge.
    task automatic expect_out(input logic [1:0] core, input logic [31:0] a, input string req);
        int n = 0;
        while (!m_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(m_valid && m_core == core && m_addr == a, req, "output core/addr",
              {m_valid, 29'd0, m_core, m_addr}, {1'b1, 29'd0, core, a});
        @(negedge clk);
    endtask

    task automatic expect_idle(input int cycles, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            if (m_valid) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, req, "no output expected", 64'(seen), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check(m_valid == 1'b0, "R12", "m_valid after reset", 64'(m_valid), 64'd0);
        check(in_ready == 2'b11, "R12", "in_ready after reset", 64'(in_ready), 64'd3);

        // R2 R3 R1: aging order (default policy aging, R7)
        m_ready = 1'b0;
        push(0, 32'h0000_0010);
        push(1, 32'hC000_0001);
        push(0, 32'h4000_0001);
        push(0, 32'h4000_0002);
        push(1, 32'h8000_0001);
        push(1, 32'hC000_0002);
        m_ready = 1'b1;
        expect_out(2'd0, 32'h0000_0010, "R1");
        expect_out(2'd3, 32'hC000_0001, "R2");
        expect_out(2'd1, 32'h4000_0001, "R2");
        expect_out(2'd2, 32'h8000_0001, "R2");
        expect_out(2'd3, 32'hC000_0002, "R3");
        expect_out(2'd1, 32'h4000_0002, "R3");
        expect_idle(3, "R1");

        // R5 R4: saturation leaves all equal, lowest index wins
        m_ready = 1'b0;
        push(0, 32'h0000_0020);
        push(1, 32'hC000_0020);
        push(1, 32'h8000_0020);
        push(0, 32'h4000_0020);
        repeat (30) @(negedge clk);
        m_ready = 1'b1;
        expect_out(2'd0, 32'h0000_0020, "R1");
        expect_out(2'd1, 32'h4000_0020, "R5");
        expect_out(2'd2, 32'h8000_0020, "R4");
        expect_out(2'd3, 32'hC000_0020, "R4");

        // R11: back-pressure on a full queue only
        m_ready = 1'b0;
        for (int i = 0; i < 5; i++) push(0, 32'h0000_0A00 + 32'(i*4));
        in_addr[31:0] = 32'h0000_0B00;
        in_addr[63:32] = 32'h8000_0B00;
        #0.5;
        check(in_ready[0] == 1'b0, "R11", "ready for full core0", 64'(in_ready[0]), 64'd0);
        check(in_ready[1] == 1'b1, "R11", "other link ready", 64'(in_ready[1]), 64'd1);
        in_addr[31:0] = 32'h4000_0B00;
        #0.5;
        check(in_ready[0] == 1'b1, "R11", "ready for core1 on same link", 64'(in_ready[0]), 64'd1);
        @(negedge clk);
        m_ready = 1'b1;
        for (int i = 0; i < 5; i++) expect_out(2'd0, 32'h0000_0A00 + 32'(i*4), "R1");

        // R6 R7: fixed priority, priorities 0,3,1,2
        cfg_write(1, 32'd0);
        cfg_write(2, 32'd3);
        cfg_write(3, 32'd1);
        cfg_write(4, 32'd2);
        cfg_write(0, 32'd1);
        @(negedge clk);
        m_ready = 1'b0;
        push(0, 32'h0000_0030);
        push(0, 32'h0000_0031);
        push(1, 32'h8000_0030);
        push(1, 32'hC000_0030);
        push(0, 32'h4000_0030);
        push(0, 32'h4000_0031);
        m_ready = 1'b1;
        expect_out(2'd0, 32'h0000_0030, "R6");
        expect_out(2'd1, 32'h4000_0030, "R6");
        expect_out(2'd1, 32'h4000_0031, "R6");
        expect_out(2'd3, 32'hC000_0030, "R6");
        expect_out(2'd2, 32'h8000_0030, "R6");
        expect_out(2'd0, 32'h0000_0031, "R6");

        // R7: illegal code 2 ignored, fixed stays in force
        cfg_write(0, 32'd2);
        @(negedge clk);
        m_ready = 1'b0;
        push(0, 32'h0000_0040);
        push(0, 32'h0000_0041);
        push(0, 32'h4000_0041);
        m_ready = 1'b1;
        expect_out(2'd0, 32'h0000_0040, "R7");
        expect_out(2'd1, 32'h4000_0041, "R7");
        expect_out(2'd0, 32'h0000_0041, "R7");

        // R8: switch to aging during a stall; grant at release edge still fixed
        m_ready = 1'b0;
        push(0, 32'h0000_0050);
        push(1, 32'h8000_0050);
        push(0, 32'h4000_0050);
        cfg_write(0, 32'd0);
        repeat (2) @(negedge clk);
        m_ready = 1'b1;
        expect_out(2'd0, 32'h0000_0050, "R8");
        expect_out(2'd1, 32'h4000_0050, "R8");
        expect_out(2'd2, 32'h8000_0050, "R8");
        // R8 R2: aging now active, older core0 head beats higher-priority core1
        m_ready = 1'b0;
        push(0, 32'h0000_0060);
        push(0, 32'h0000_0061);
        push(0, 32'h4000_0061);
        m_ready = 1'b1;
        expect_out(2'd0, 32'h0000_0060, "R8");
        expect_out(2'd0, 32'h0000_0061, "R8");
        expect_out(2'd1, 32'h4000_0061, "R8");

        // R9 R10: reprogrammed routing
        cfg_write(10, 32'hF000_0000);
        cfg_write(11, 32'hF000_0000);
        push(0, 32'hF000_0040);
        expect_out(2'd1, 32'hF000_0040, "R9");
        in_addr[31:0] = 32'h4000_0070;
        #0.5;
        check(in_ready[0] == 1'b1, "R10", "unmatched request accepted", 64'(in_ready[0]), 64'd1);
        @(negedge clk);
        push(0, 32'h4000_0070);
        expect_idle(4, "R10");
        cfg_write(8, 32'hE000_0000);
        cfg_write(9, 32'hE000_0000);
        push(0, 32'hF000_0080);
        expect_out(2'd0, 32'hF000_0080, "R9");
        push(1, 32'h0000_0090);
        expect_idle(4, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule